// File: doc/BRIEF.md
# UART Banked Register File

This block is the host-facing register file of a 16550-class serial port. A host drives a 3-bit address, an 8-bit write bus and separate read and write strobes. The block decodes each access, keeps the control registers, multiplexes status and stored values onto the read bus, and exports every stored field to the rest of the UART. The serial shifters, FIFOs, baud counter, interrupt logic and flow-control engines are outside the block. They appear only as status inputs and control outputs.

The line control value chooses what each address reaches. With its top bit clear, the standard map is visible. With the top bit set, addresses 0 and 1 reach the two halves of the baud divisor. The exact value 0xBF opens a further bank. In that bank, address 2 is the enhanced feature register and addresses 4 to 7 are the four flow-control character registers. Bit 4 of the enhanced feature register is an unlock bit. While it is clear, writes to certain upper bits of the interrupt enable, FIFO control and modem control registers are dropped, and the interrupt status bits 5:4 read as zero.

Data moves through address 0. Reading address 0 pops the receive path through a valid/ready pair: `rx_ready` is the pop request, and a pop happens only when `rx_valid` is also high. Writing address 0 pushes the transmit path with a one-cycle `tx_valid` pulse. There is no transmit back-pressure: the transmit FIFO takes the pulse or handles its own overflow, and the host must check line status before it writes.

Top module: `uart_regbank`

## Requirements
- R1: After reset, every stored register reads and exports as 0x00, except line control, which is 0x03.
- R2: With line control bit 7 clear, a write to address 0 drives `tx_valid` high and `tx_data` equal to the write data in that same cycle, and changes no stored register.
- R3: With line control bit 7 set, addresses 0 and 1 write and read the low and high divisor bytes (`divisor_o` = {high, low}), and `tx_valid` stays low.
- R4: With line control exactly 0xBF, address 2 reads and writes the enhanced feature register. Addresses 4 to 7 write the characters packed into `flow_chars_o` bytes 0 to 3. Reads of addresses 4 to 7 return 0x00, and writes there leave modem control unchanged.
- R5: With line control at 0xBF, addresses 0 and 1 still reach the divisor bytes, and address 3 still reaches line control.
- R6: While enhanced feature bit 4 is 0, a write leaves these bits at their old values: interrupt enable bits 7:4, FIFO control bits 5:4, and modem control bits 7:5 and 2. All other bits of the written byte are stored.
- R7: While enhanced feature bit 4 is 1, those same registers take the full written byte.
- R8: A read of address 2 outside the 0xBF bank returns `isr_i`, with bits 5:4 forced to 0 while enhanced feature bit 4 is 0.
- R9: The enhanced feature fields are exported at fixed bits: auto-CTS enable at bit 7, auto-RTS enable at bit 6, special-character enable at bit 5, and the flow-control select field at bits 3:0.
- R10: `rx_ready` is high only during a read of address 0 with line control bit 7 clear. That read returns `rx_data` when `rx_valid` is high and 0x00 otherwise.
- R11: A read in the same cycle as a write returns the state before the write. The written value, including a new bank selection, takes effect from the next cycle.
- R12: Address 5 reads `lsr_i`, address 6 reads `msr_i`, and address 7 outside the 0xBF bank is a scratch byte that reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from address and state |
| rx_valid | input | 1 | Receive FIFO holds a character |
| rx_data | input | 8 | Head of the receive FIFO |
| rx_ready | output | 1 | Pop request for the receive FIFO |
| tx_valid | output | 1 | Push strobe for the transmit FIFO |
| tx_data | output | 8 | Character pushed to transmit |
| isr_i | input | 8 | Interrupt status from the interrupt logic |
| lsr_i | input | 8 | Line status |
| msr_i | input | 8 | Modem status |
| lcr_o | output | 8 | Line control |
| ier_o | output | 8 | Interrupt enable |
| fcr_o | output | 8 | FIFO control |
| mcr_o | output | 8 | Modem control |
| efr_o | output | 8 | Enhanced feature register |
| divisor_o | output | 16 | Baud divisor {high, low} |
| flow_chars_o | output | 32 | {XOFF2, XOFF1, XON2, XON1} |

## Verification
A host read and a host write can land in the same cycle. The case that matters is a write of 0xBF to line control while address 3 is read. The bench provokes it by raising both strobes on one address in one cycle. Two results are judged. The read must show the old line control value in that cycle. A read of address 2 on the following access must then return the enhanced feature register instead of the interrupt status, which shows the bank changed exactly one edge later.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int REG_W = 8;
  localparam int NUM_FLOW = 4;

  typedef enum logic [3:0] {
    SEL_DATA   = 4'd0,
    SEL_IER    = 4'd1,
    SEL_ISRFCR = 4'd2,
    SEL_LCR    = 4'd3,
    SEL_MCR    = 4'd4,
    SEL_LSR    = 4'd5,
    SEL_MSR    = 4'd6,
    SEL_SPR    = 4'd7,
    SEL_DLL    = 4'd8,
    SEL_DLM    = 4'd9,
    SEL_EFR    = 4'd10,
    SEL_FLOW0  = 4'd11,
    SEL_FLOW1  = 4'd12,
    SEL_FLOW2  = 4'd13,
    SEL_FLOW3  = 4'd14
  } sel_e;

  localparam logic [3:0] FLOW_BASE = 4'd11;

  // Bits that only change while the unlock bit is set
  localparam logic [REG_W-1:0] IER_LOCK_M = 8'hF0;
  localparam logic [REG_W-1:0] FCR_LOCK_M = 8'h30;
  localparam logic [REG_W-1:0] MCR_LOCK_M = 8'hE4;
  localparam logic [REG_W-1:0] ISR_LOCK_M = 8'h30;
  localparam int UNLOCK_BIT = 4;

  function automatic logic [REG_W-1:0] gated_wr(
    input logic [REG_W-1:0] old_v,
    input logic [REG_W-1:0] new_v,
    input logic [REG_W-1:0] lock_m,
    input logic             unlocked
  );
    gated_wr = unlocked ? new_v : ((new_v & ~lock_m) | (old_v & lock_m));
  endfunction
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
#(
  parameter logic [REG_W-1:0] KEY_VAL = 8'hBF,
  parameter int               DLAB_BIT = 7
) (
  input  logic [2:0]       addr,
  input  logic [REG_W-1:0] lcr,
  output sel_e             sel
);
  logic key_bank;
  logic div_bank;

  assign key_bank = (lcr == KEY_VAL);
  assign div_bank = lcr[DLAB_BIT];

  always_comb begin
    sel = SEL_DATA;
    unique case (addr)
      3'd0: sel = div_bank ? SEL_DLL : SEL_DATA;
      3'd1: sel = div_bank ? SEL_DLM : SEL_IER;
      3'd2: sel = key_bank ? SEL_EFR : SEL_ISRFCR;
      3'd3: sel = SEL_LCR;
      3'd4: sel = key_bank ? SEL_FLOW0 : SEL_MCR;
      3'd5: sel = key_bank ? SEL_FLOW1 : SEL_LSR;
      3'd6: sel = key_bank ? SEL_FLOW2 : SEL_MSR;
      3'd7: sel = key_bank ? SEL_FLOW3 : SEL_SPR;
      default: sel = SEL_DATA;
    endcase
  end
endmodule

// File: rtl/uart_rb_regs.sv
module uart_rb_regs
  import uart_rb_pkg::*;
#(
  parameter logic [REG_W-1:0] LCR_RST = 8'h03
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  sel_e                      sel,
  input  logic [REG_W-1:0]          wdata,
  output logic [REG_W-1:0]          lcr,
  output logic [REG_W-1:0]          ier,
  output logic [REG_W-1:0]          fcr,
  output logic [REG_W-1:0]          mcr,
  output logic [REG_W-1:0]          efr,
  output logic [REG_W-1:0]          spr,
  output logic [REG_W-1:0]          dll,
  output logic [REG_W-1:0]          dlm,
  output logic [NUM_FLOW*REG_W-1:0] flow
);
  logic unlocked;
  assign unlocked = efr[UNLOCK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr <= LCR_RST;
      ier <= '0;
      fcr <= '0;
      mcr <= '0;
      efr <= '0;
      spr <= '0;
      dll <= '0;
      dlm <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_LCR:    lcr <= wdata;
        SEL_IER:    ier <= gated_wr(ier, wdata, IER_LOCK_M, unlocked);
        SEL_ISRFCR: fcr <= gated_wr(fcr, wdata, FCR_LOCK_M, unlocked);
        SEL_MCR:    mcr <= gated_wr(mcr, wdata, MCR_LOCK_M, unlocked);
        SEL_EFR:    efr <= wdata;
        SEL_SPR:    spr <= wdata;
        SEL_DLL:    dll <= wdata;
        SEL_DLM:    dlm <= wdata;
        default:    ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_FLOW; i++) begin : g_flow
    logic hit;
    assign hit = wr_en && (sel == sel_e'(FLOW_BASE + 4'(i)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flow[i*REG_W +: REG_W] <= '0;
      else if (hit) flow[i*REG_W +: REG_W] <= wdata;
    end
  end
endmodule

// File: rtl/uart_rb_rdmux.sv
module uart_rb_rdmux
  import uart_rb_pkg::*;
(
  input  sel_e             sel,
  input  logic             unlocked,
  input  logic             rx_valid,
  input  logic [REG_W-1:0] rx_data,
  input  logic [REG_W-1:0] isr_i,
  input  logic [REG_W-1:0] lsr_i,
  input  logic [REG_W-1:0] msr_i,
  input  logic [REG_W-1:0] lcr,
  input  logic [REG_W-1:0] ier,
  input  logic [REG_W-1:0] mcr,
  input  logic [REG_W-1:0] efr,
  input  logic [REG_W-1:0] spr,
  input  logic [REG_W-1:0] dll,
  input  logic [REG_W-1:0] dlm,
  output logic [REG_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    case (sel)
      SEL_DATA:   rdata = rx_valid ? rx_data : '0;
      SEL_IER:    rdata = ier;
      SEL_ISRFCR: rdata = unlocked ? isr_i : (isr_i & ~ISR_LOCK_M);
      SEL_LCR:    rdata = lcr;
      SEL_MCR:    rdata = mcr;
      SEL_LSR:    rdata = lsr_i;
      SEL_MSR:    rdata = msr_i;
      SEL_SPR:    rdata = spr;
      SEL_DLL:    rdata = dll;
      SEL_DLM:    rdata = dlm;
      SEL_EFR:    rdata = efr;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter logic [REG_W-1:0] KEY_VAL  = 8'hBF,
  parameter logic [REG_W-1:0] LCR_RST  = 8'h03,
  parameter int               DLAB_BIT = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                addr,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [REG_W-1:0]          wdata,
  output logic [REG_W-1:0]          rdata,
  input  logic                      rx_valid,
  input  logic [REG_W-1:0]          rx_data,
  output logic                      rx_ready,
  output logic                      tx_valid,
  output logic [REG_W-1:0]          tx_data,
  input  logic [REG_W-1:0]          isr_i,
  input  logic [REG_W-1:0]          lsr_i,
  input  logic [REG_W-1:0]          msr_i,
  output logic [REG_W-1:0]          lcr_o,
  output logic [REG_W-1:0]          ier_o,
  output logic [REG_W-1:0]          fcr_o,
  output logic [REG_W-1:0]          mcr_o,
  output logic [REG_W-1:0]          efr_o,
  output logic [2*REG_W-1:0]        divisor_o,
  output logic [NUM_FLOW*REG_W-1:0] flow_chars_o
);
  sel_e             sel;
  logic [REG_W-1:0] spr, dll, dlm;

  uart_rb_decode #(.KEY_VAL(KEY_VAL), .DLAB_BIT(DLAB_BIT)) u_dec (
    .addr (addr),
    .lcr  (lcr_o),
    .sel  (sel)
  );

  uart_rb_regs #(.LCR_RST(LCR_RST)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .sel   (sel),
    .wdata (wdata),
    .lcr   (lcr_o),
    .ier   (ier_o),
    .fcr   (fcr_o),
    .mcr   (mcr_o),
    .efr   (efr_o),
    .spr   (spr),
    .dll   (dll),
    .dlm   (dlm),
    .flow  (flow_chars_o)
  );

  uart_rb_rdmux u_mux (
    .sel      (sel),
    .unlocked (efr_o[UNLOCK_BIT]),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .isr_i    (isr_i),
    .lsr_i    (lsr_i),
    .msr_i    (msr_i),
    .lcr      (lcr_o),
    .ier      (ier_o),
    .mcr      (mcr_o),
    .efr      (efr_o),
    .spr      (spr),
    .dll      (dll),
    .dlm      (dlm),
    .rdata    (rdata)
  );

  assign rx_ready  = rd_en && (sel == SEL_DATA);
  assign tx_valid  = wr_en && (sel == SEL_DATA);
  assign tx_data   = wdata;
  assign divisor_o = {dlm, dll};
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic        rx_ready,
  input logic        tx_valid,
  input logic [7:0]  tx_data,
  input logic [7:0]  lcr_o,
  input logic [7:0]  ier_o,
  input logic [7:0]  mcr_o,
  input logic [7:0]  efr_o,
  input logic [15:0] divisor_o
);
  // R2
  tx_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (wr_en && tx_data == wdata && addr == 3'd0));

  // R3
  no_push_in_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lcr_o[7] && addr == 3'd0) |-> !tx_valid);

  // R4
  flow_wr_keeps_mcr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lcr_o == 8'hBF && addr == 3'd4) |=> (mcr_o == $past(mcr_o)));

  // R5
  key_bank_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lcr_o == 8'hBF && addr == 3'd0) |=> (divisor_o[7:0] == $past(wdata)));

  // R6
  ier_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !efr_o[4] && !lcr_o[7] && addr == 3'd1) |=> (ier_o[7:4] == $past(ier_o[7:4])));

  // R8
  isr_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !efr_o[4] && lcr_o != 8'hBF && addr == 3'd2) |-> (rdata[5:4] == 2'b00));

  // R10
  pop_only_rhr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (rd_en && addr == 3'd0 && !lcr_o[7]));
endmodule

bind uart_regbank uart_regbank_chk i_chk (.*);

// File: tb/test_uart_regbank.sv
module test_uart_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid;
  logic [7:0]  tx_data;
  logic [7:0]  isr_i = '0, lsr_i = '0, msr_i = '0;
  logic [7:0]  lcr_o, ier_o, fcr_o, mcr_o, efr_o;
  logic [15:0] divisor_o;
  logic [31:0] flow_chars_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  uart_regbank i_uart_regbank (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic pop);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #2;
    d = rdata; pop = rx_ready;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic p;
    chk("R1 lcr", lcr_o, 8'h03);
    chk("R1 ier", ier_o, 0);
    chk("R1 fcr", fcr_o, 0);
    chk("R1 mcr", mcr_o, 0);
    chk("R1 efr", efr_o, 0);
    chk("R1 div", divisor_o, 0);
    chk("R1 flow", flow_chars_o, 0);
    rd(3'd3, d, p);
    chk("R1 lcr read", d, 8'h03);
  endtask

  task automatic t_data_path;
    logic [7:0] d; logic p;
    rx_valid = 1'b1; rx_data = 8'hA5;
    rd(3'd0, d, p);
    chk("R10 rhr data", d, 8'hA5);
    chk("R10 pop", p, 1);
    rx_valid = 1'b0;
    rd(3'd0, d, p);
    chk("R10 empty read", d, 8'h00);
    rd(3'd1, d, p);
    chk("R10 no pop at ier", p, 0);
    @(negedge clk);
    addr = 3'd0; wdata = 8'h3C; wr_en = 1'b1;
    #2;
    chk("R2 tx_valid", tx_valid, 1);
    chk("R2 tx_data", tx_data, 8'h3C);
    @(negedge clk);
    wr_en = 1'b0;
    #2;
    chk("R2 tx_valid drops", tx_valid, 0);
    chk("R2 lcr kept", lcr_o, 8'h03);
  endtask

  task automatic t_divisor;
    logic [7:0] d; logic p;
    wr(3'd3, 8'h80);
    @(negedge clk);
    addr = 3'd0; wdata = 8'h34; wr_en = 1'b1;
    #2;
    chk("R3 no tx push", tx_valid, 0);
    @(negedge clk);
    wr_en = 1'b0;
    wr(3'd1, 8'h12);
    chk("R3 divisor", divisor_o, 16'h1234);
    rd(3'd0, d, p);
    chk("R3 dll read", d, 8'h34);
    chk("R3 no pop", p, 0);
    isr_i = 8'hC1;
    rd(3'd2, d, p);
    chk("R8 isr in div bank", d, 8'hC1);
    wr(3'd3, 8'h03);
  endtask

  task automatic t_locked;
    logic [7:0] d; logic p;
    wr(3'd1, 8'hFF);
    chk("R6 ier locked", ier_o, 8'h0F);
    wr(3'd4, 8'hFF);
    chk("R6 mcr locked", mcr_o, 8'h1B);
    wr(3'd2, 8'hFF);
    chk("R6 fcr locked", fcr_o, 8'hCF);
    isr_i = 8'hFF;
    rd(3'd2, d, p);
    chk("R8 isr masked", d, 8'hCF);
  endtask

  task automatic t_key_bank;
    logic [7:0] d; logic p;
    wr(3'd3, 8'hBF);
    wr(3'd2, 8'hD5);
    chk("R4 efr", efr_o, 8'hD5);
    chk("R6 fcr untouched", fcr_o, 8'hCF);
    rd(3'd2, d, p);
    chk("R4 efr read", d, 8'hD5);
    chk("R9 auto cts", efr_o[7], 1);
    chk("R9 auto rts", efr_o[6], 1);
    chk("R9 special", efr_o[5], 0);
    chk("R9 flow select", efr_o[3:0], 4'h5);
    wr(3'd4, 8'h11);
    wr(3'd5, 8'h22);
    wr(3'd6, 8'h33);
    wr(3'd7, 8'h44);
    chk("R4 flow chars", flow_chars_o, 32'h44332211);
    chk("R4 mcr kept", mcr_o, 8'h1B);
    rd(3'd4, d, p);
    chk("R4 write-only read", d, 8'h00);
    rd(3'd7, d, p);
    chk("R4 write-only read 7", d, 8'h00);
    wr(3'd0, 8'h78);
    chk("R5 div low in key bank", divisor_o, 16'h1278);
    rd(3'd3, d, p);
    chk("R5 lcr read", d, 8'hBF);
  endtask

  task automatic t_unlocked;
    logic [7:0] d; logic p;
    wr(3'd3, 8'h03);
    wr(3'd1, 8'hFF);
    chk("R7 ier full", ier_o, 8'hFF);
    wr(3'd4, 8'hFF);
    chk("R7 mcr full", mcr_o, 8'hFF);
    wr(3'd2, 8'hFF);
    chk("R7 fcr full", fcr_o, 8'hFF);
    isr_i = 8'hFF;
    rd(3'd2, d, p);
    chk("R8 isr unmasked", d, 8'hFF);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d; logic p;
    @(negedge clk);
    addr = 3'd3; wdata = 8'hBF; wr_en = 1'b1; rd_en = 1'b1;
    #2;
    chk("R11 read sees old lcr", rdata, 8'h03);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    isr_i = 8'h01;
    rd(3'd2, d, p);
    chk("R11 new bank next cycle", d, 8'hD5);
    wr(3'd3, 8'h03);
  endtask

  task automatic t_status;
    logic [7:0] d; logic p;
    lsr_i = 8'h61; msr_i = 8'hB0;
    rd(3'd5, d, p);
    chk("R12 lsr", d, 8'h61);
    rd(3'd6, d, p);
    chk("R12 msr", d, 8'hB0);
    wr(3'd7, 8'h9E);
    rd(3'd7, d, p);
    chk("R12 scratch", d, 8'h9E);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data_path();
    t_divisor();
    t_locked();
    t_key_bank();
    t_unlocked();
    t_same_cycle();
    t_status();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule